// File: doc/BRIEF.md
# AC-link Codec Command Sequencer

This block sits above an AC-link frame serializer and decides what goes into the tag and slots 1 to 4 of every outgoing frame. Once per frame the serializer pulses `frame_strobe` and presents the slots it has just received. The sequencer samples them and loads the contents of the next outgoing frame, which stay stable until the following strobe.

After the chip reset is released, the block holds the codec reset line low for a fixed number of clocks. It then sends empty frames until the codec raises its ready bit. Once the codec is ready, it plays a parameterised list of register-write commands, one per frame. After that it carries PCM audio in slots 3 and 4, looped back from the received slots. A host port can queue a single register write or register read at a time. A read completes when the codec returns a status frame carrying the register address and its data.

Top module: `aclink_cmd_seq`

## Requirements
- R1: `codec_rst_n` is low for exactly RST_HOLD rising clock edges after `rst_n` is released, then goes high and stays high until the next `rst_n` assertion.
- R2: At a strobe where `codec_rst_n` is still low or received tag bit 15 (codec ready) is 0, the next outgoing frame is all zeroes: the tag and all four slots.
- R3: Once the codec is ready, the init list is sent in index order, one entry per strobe. Entry i is taken from INIT_LIST bits [i*23 +: 23] as {addr[6:0], data[15:0]}. Each entry goes out as tag 0xE000, slot 1 = {1'b0, addr, 12'h000} and slot 2 = {data, 4'h0}.
- R4: `init_done` rises with the frame that carries the last init entry and then stays high until reset.
- R5: If the ready bit drops after the first init entry has been sent, frames are zero while it is low. When ready returns, the block resumes where it stopped: it continues the list from the next unsent entry, or returns to normal traffic if the list is complete. Entries are never replayed.
- R6: A normal frame has tag 0x9800, which marks slots 3 and 4 valid. Slots 1 and 2 are zero. Slots 3 and 4 carry the received slots 3 and 4 with bits 3:0 cleared.
- R7: A request is accepted on a clock where `req_valid` is high and `busy` is low. `busy` is high from the next clock. For a write it stays high until the command frame is loaded; for a read it stays high until the response is captured.
- R8: An accepted write, once the init list is complete and the codec is ready, is loaded as the next frame with tag 0xE000, slot 1 = {1'b0, addr, 12'h000}, slot 2 = {wdata, 4'h0} and slots 3 and 4 zero.
- R9: An accepted read is loaded in the same way but with slot 1 = {1'b1, addr, 12'h000} and slot 2 zero.
- R10: With a read outstanding, a strobe whose received tag has bits 15, 14 and 13 set gives a one-clock `rd_valid` pulse on the next clock. `rd_addr` is received slot 1 bits 18:12 and `rd_data` is received slot 2 bits 19:4.
- R11: A received frame with tag bits 14 and 13 set while no read is outstanding produces no `rd_valid` pulse.
- R12: A request presented while `busy` is high is ignored. The pending command is sent unchanged.
- R13: A pending command occupies exactly one frame. The frame after it is a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One-clock pulse per frame: received slots valid, next frame loaded |
| rx_tag | input | 16 | Received tag slot |
| rx_slot1 | input | 20 | Received slot 1 (status address) |
| rx_slot2 | input | 20 | Received slot 2 (status data) |
| rx_slot3 | input | 20 | Received slot 3 (PCM left) |
| rx_slot4 | input | 20 | Received slot 4 (PCM right) |
| req_valid | input | 1 | Host request strobe |
| req_is_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A command is pending or a read is outstanding |
| codec_rst_n | output | 1 | Codec reset, active low |
| tx_tag | output | 16 | Outgoing tag slot |
| tx_slot1 | output | 20 | Outgoing slot 1 |
| tx_slot2 | output | 20 | Outgoing slot 2 |
| tx_slot3 | output | 20 | Outgoing slot 3 |
| tx_slot4 | output | 20 | Outgoing slot 4 |
| rd_valid | output | 1 | Read result pulse |
| rd_addr | output | 7 | Address of the read result |
| rd_data | output | 16 | Data of the read result |
| init_done | output | 1 | Init list fully sent |

## Verification
Several input patterns are applied. A ready bit that rises during codec reset checks that strobes are held off until the reset timer expires. A ready bit that drops both during the init list and after it separates resuming the list from replaying it. Random PCM samples on every frame reveal any leak of the low four bits. A write followed at once by a second request tells a queued command apart from one that is overwritten, and a status-shaped frame sent before any read shows whether responses are tied to an outstanding read. Boundary values (address 0x7F, data 0xFFFF, address 0) check that the fields are placed in the right bits.

// File: rtl/aclink_seq_pkg.sv
package aclink_seq_pkg;

  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int ENTRY_W = ADDR_W + DATA_W;

  // tag bit positions decoded by the codec
  localparam int TB_FRAME = 15;
  localparam int TB_S1    = 14;
  localparam int TB_S2    = 13;
  localparam int TB_S3    = 12;
  localparam int TB_S4    = 11;

  localparam int RW_BIT   = SLOT_W - 1;
  localparam int ADDR_LSB = SLOT_W - 1 - ADDR_W - 1 + 1 - 0; // 12
  localparam int DATA_LSB = SLOT_W - DATA_W;                 // 4

  localparam logic [SLOT_W-1:0] PCM_MASK = ~SLOT_W'((1 << DATA_LSB) - 1);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [SLOT_W-1:0] s1;
    logic [SLOT_W-1:0] s2;
    logic [SLOT_W-1:0] s3;
    logic [SLOT_W-1:0] s4;
  } frame_t;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_PCM  = 2'd3
  } frame_sel_e;

  function automatic frame_t make_cmd(input logic is_read,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic [DATA_W-1:0] data);
    frame_t f;
    f              = '0;
    f.tag[TB_FRAME] = 1'b1;
    f.tag[TB_S1]    = 1'b1;
    f.tag[TB_S2]    = 1'b1;
    f.s1           = {is_read, addr, {ADDR_LSB{1'b0}}};
    f.s2           = is_read ? '0 : {data, {DATA_LSB{1'b0}}};
    return f;
  endfunction

  function automatic frame_t make_pcm(input logic [SLOT_W-1:0] left,
                                      input logic [SLOT_W-1:0] right);
    frame_t f;
    f               = '0;
    f.tag[TB_FRAME] = 1'b1;
    f.tag[TB_S3]    = 1'b1;
    f.tag[TB_S4]    = 1'b1;
    f.s3            = left & PCM_MASK;
    f.s4            = right & PCM_MASK;
    return f;
  endfunction

endpackage

// File: rtl/aclink_rst_timer.sv
module aclink_rst_timer #(
  parameter int HOLD = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic released
);

  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_d;

  always_comb begin
    cnt_d = cnt_q;
    rel_d = released;
    if (!released) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(HOLD - 1)) rel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      released <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      released <= rel_d;
    end
  end

endmodule

// File: rtl/aclink_init_list.sv
module aclink_init_list
  import aclink_seq_pkg::*;
#(
  parameter int                      LEN  = 4,
  parameter logic [LEN*ENTRY_W-1:0]  LIST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              done
);

  localparam int CW = $clog2(LEN + 1);
  localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [ENTRY_W-1:0] entries [LEN];
  logic [CW-1:0]      left_q, left_d;
  logic [IW-1:0]      ptr_q, ptr_d;

  for (genvar g = 0; g < LEN; g++) begin : g_entry
    assign entries[g] = LIST[g*ENTRY_W +: ENTRY_W];
  end

  assign done = (left_q == '0);
  assign {addr, data} = entries[ptr_q];

  always_comb begin
    left_d = left_q;
    ptr_d  = ptr_q;
    if (advance && !done) begin
      left_d = left_q - 1'b1;
      if (left_q != CW'(1)) ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= CW'(LEN);
      ptr_q  <= '0;
    end else begin
      left_q <= left_d;
      ptr_q  <= ptr_d;
    end
  end

endmodule

// File: rtl/aclink_host_port.sv
module aclink_host_port
  import aclink_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              send,
  input  logic              resp_hit,
  output logic              busy,
  output logic              pend,
  output logic              cmd_is_read,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_wait
);

  logic accept;
  logic pend_d, wait_d;

  assign busy   = pend | rd_wait;
  assign accept = req_valid & ~busy;

  always_comb begin
    pend_d = pend;
    wait_d = rd_wait;
    if (send)     pend_d = 1'b0;
    if (accept)   pend_d = 1'b1;
    if (resp_hit) wait_d = 1'b0;
    if (send && cmd_is_read) wait_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      rd_wait <= 1'b0;
    end else begin
      pend    <= pend_d;
      rd_wait <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_is_read <= 1'b0;
      cmd_addr    <= '0;
      cmd_wdata   <= '0;
    end else if (accept) begin
      cmd_is_read <= req_is_read;
      cmd_addr    <= req_addr;
      cmd_wdata   <= req_wdata;
    end
  end

endmodule

// File: rtl/aclink_resp_capture.sv
module aclink_resp_capture
  import aclink_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [SLOT_W-1:0] slot1,
  input  logic [SLOT_W-1:0] slot2,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic unused_bits;
  assign unused_bits = ^{slot1[RW_BIT], slot1[ADDR_LSB-1:0], slot2[DATA_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      rd_data <= '0;
    end else if (hit) begin
      rd_addr <= slot1[ADDR_LSB +: ADDR_W];
      rd_data <= slot2[DATA_LSB +: DATA_W];
    end
  end

endmodule

// File: rtl/aclink_cmd_seq.sv
module aclink_cmd_seq
  import aclink_seq_pkg::*;
#(
  parameter int                         RST_HOLD  = 64,
  parameter int                         INIT_LEN  = 4,
  parameter logic [INIT_LEN*ENTRY_W-1:0] INIT_LIST = {7'h2C, 16'hBB80,
                                                      7'h10, 16'h0808,
                                                      7'h18, 16'h0808,
                                                      7'h02, 16'h0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_strobe,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [SLOT_W-1:0] rx_slot1,
  input  logic [SLOT_W-1:0] rx_slot2,
  input  logic [SLOT_W-1:0] rx_slot3,
  input  logic [SLOT_W-1:0] rx_slot4,
  input  logic              req_valid,
  input  logic              req_is_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              codec_rst_n,
  output logic [TAG_W-1:0]  tx_tag,
  output logic [SLOT_W-1:0] tx_slot1,
  output logic [SLOT_W-1:0] tx_slot2,
  output logic [SLOT_W-1:0] tx_slot3,
  output logic [SLOT_W-1:0] tx_slot4,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              init_done
);

  logic              ready;
  logic              resp_hit;
  logic              init_adv;
  logic              cmd_send;
  logic [ADDR_W-1:0] init_addr;
  logic [DATA_W-1:0] init_data;
  logic              pend, rd_wait, cmd_is_read;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata;
  frame_sel_e        sel;
  frame_t            frame_q, frame_d, frame_nx;
  logic              unused_tag;

  assign unused_tag = ^rx_tag[TB_S2-1:0];

  aclink_rst_timer #(.HOLD(RST_HOLD)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .released (codec_rst_n)
  );

  aclink_init_list #(.LEN(INIT_LEN), .LIST(INIT_LIST)) u_init (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (init_adv),
    .addr    (init_addr),
    .data    (init_data),
    .done    (init_done)
  );

  aclink_host_port u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_is_read (req_is_read),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .send        (cmd_send),
    .resp_hit    (resp_hit),
    .busy        (busy),
    .pend        (pend),
    .cmd_is_read (cmd_is_read),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .rd_wait     (rd_wait)
  );

  aclink_resp_capture u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (resp_hit),
    .slot1    (rx_slot1),
    .slot2    (rx_slot2),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  // frame selection and strobe qualifiers
  always_comb begin
    ready    = codec_rst_n & rx_tag[TB_FRAME];
    resp_hit = frame_strobe & ready & rx_tag[TB_S1] & rx_tag[TB_S2] & rd_wait;
    if (!ready)          sel = SEL_ZERO;
    else if (!init_done) sel = SEL_INIT;
    else if (pend)       sel = SEL_CMD;
    else                 sel = SEL_PCM;
    init_adv = frame_strobe & (sel == SEL_INIT);
    cmd_send = frame_strobe & (sel == SEL_CMD);
  end

  always_comb begin
    unique case (sel)
      SEL_ZERO: frame_d = '0;
      SEL_INIT: frame_d = make_cmd(1'b0, init_addr, init_data);
      SEL_CMD:  frame_d = make_cmd(cmd_is_read, cmd_addr, cmd_wdata);
      default:  frame_d = make_pcm(rx_slot3, rx_slot4);
    endcase
    frame_nx = frame_strobe ? frame_d : frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_nx;
  end

  assign tx_tag   = frame_q.tag;
  assign tx_slot1 = frame_q.s1;
  assign tx_slot2 = frame_q.s2;
  assign tx_slot3 = frame_q.s3;
  assign tx_slot4 = frame_q.s4;

endmodule

// File: rtl/aclink_cmd_seq_chk.sv
module aclink_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_strobe,
  input logic [15:0] rx_tag,
  input logic        req_valid,
  input logic        busy,
  input logic        codec_rst_n,
  input logic [15:0] tx_tag,
  input logic [19:0] tx_slot1,
  input logic [19:0] tx_slot2,
  input logic        rd_valid,
  input logic        init_done
);

  // R1: once released, the codec reset stays released
  a_r1_reset_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst_n |=> codec_rst_n);

  // R2: frames stay empty while the codec is held in reset
  a_r2_zero_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n |-> (tx_tag == 16'h0 && tx_slot1 == 20'h0 && tx_slot2 == 20'h0));

  // R2: a strobe without the ready bit loads an empty tag
  a_r2_zero_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !rx_tag[15]) |=> (tx_tag == 16'h0));

  // R3: the outgoing frame changes only at a strobe
  a_r3_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> ($stable(tx_tag) && $stable(tx_slot1) && $stable(tx_slot2)));

  // R4: init completion is sticky
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7: an accepted request makes the port busy
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R10: a read result is a single-clock pulse
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R6, R8: only empty, command or audio tags are ever produced
  a_r8_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag == 16'h0000 || tx_tag == 16'hE000 || tx_tag == 16'h9800));

endmodule

bind aclink_cmd_seq aclink_cmd_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_strobe (frame_strobe),
  .rx_tag       (rx_tag),
  .req_valid    (req_valid),
  .busy         (busy),
  .codec_rst_n  (codec_rst_n),
  .tx_tag       (tx_tag),
  .tx_slot1     (tx_slot1),
  .tx_slot2     (tx_slot2),
  .rd_valid     (rd_valid),
  .init_done    (init_done)
);

// File: tb/tb_aclink_cmd_seq.sv
module tb_aclink_cmd_seq;

  localparam int RST = 64;
  localparam int LEN = 4;
  localparam int GAP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        frame_strobe = 1'b0;
  logic [15:0] rx_tag = '0;
  logic [19:0] rx_slot1 = '0, rx_slot2 = '0, rx_slot3 = '0, rx_slot4 = '0;
  logic        req_valid = 1'b0, req_is_read = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, codec_rst_n, rd_valid, init_done;
  logic [15:0] tx_tag, rd_data;
  logic [19:0] tx_slot1, tx_slot2, tx_slot3, tx_slot4;
  logic [6:0]  rd_addr;

  aclink_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .rx_tag(rx_tag),
    .rx_slot1(rx_slot1), .rx_slot2(rx_slot2), .rx_slot3(rx_slot3), .rx_slot4(rx_slot4),
    .req_valid(req_valid), .req_is_read(req_is_read), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .codec_rst_n(codec_rst_n), .tx_tag(tx_tag),
    .tx_slot1(tx_slot1), .tx_slot2(tx_slot2), .tx_slot3(tx_slot3), .tx_slot4(tx_slot4),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .init_done(init_done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // init list as the requirement R3 defines it
  logic [6:0]  ia [LEN] = '{7'h02, 7'h18, 7'h10, 7'h2C};
  logic [15:0] id [LEN] = '{16'h0000, 16'h0808, 16'h0808, 16'hBB80};

  // reference model state
  int          m_edges;
  bit          m_crst, m_done, m_pend, m_pread, m_wait, m_after, m_ignored;
  int          m_idx;
  logic [6:0]  m_paddr;
  logic [15:0] m_pdata;
  logic [15:0] e_tag;
  logic [19:0] e_s1, e_s2, e_s3, e_s4;
  bit          e_rdv;
  logic [6:0]  e_rda;
  logic [15:0] e_rdd;
  string       e_kind = "R2";
  string       rd_kind = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0; m_crst = 0; m_done = 0; m_pend = 0; m_pread = 0; m_wait = 0;
      m_after = 0; m_ignored = 0; m_idx = 0; m_paddr = '0; m_pdata = '0;
      e_tag = '0; e_s1 = '0; e_s2 = '0; e_s3 = '0; e_s4 = '0; e_kind = "R2";
      e_rdv = 0; e_rda = '0; e_rdd = '0; rd_kind = "R10";
    end else begin
      bit busy_old, rdy;
      busy_old = m_pend || m_wait;
      rdy = m_crst && rx_tag[15];
      e_rdv = 0;
      rd_kind = "R10";
      if (frame_strobe) begin
        if (rdy && rx_tag[14] && rx_tag[13]) begin
          if (m_wait) begin
            e_rdv = 1; e_rda = rx_slot1[18:12]; e_rdd = rx_slot2[19:4]; m_wait = 0;
          end else rd_kind = "R11";
        end
        if (!rdy) begin
          e_tag = '0; e_s1 = '0; e_s2 = '0; e_s3 = '0; e_s4 = '0;
          e_kind = (m_crst && (m_idx > 0)) ? "R5" : "R2";
        end else if (!m_done) begin
          e_tag = 16'hE000; e_s1 = {1'b0, ia[m_idx], 12'h000}; e_s2 = {id[m_idx], 4'h0};
          e_s3 = '0; e_s4 = '0; e_kind = "R3";
          m_idx++;
          if (m_idx == LEN) m_done = 1;
        end else if (m_pend) begin
          e_tag = 16'hE000; e_s1 = {m_pread, m_paddr, 12'h000};
          e_s2 = m_pread ? 20'h0 : {m_pdata, 4'h0}; e_s3 = '0; e_s4 = '0;
          e_kind = m_ignored ? "R12" : (m_pread ? "R9" : "R8");
          m_ignored = 0; m_pend = 0; m_after = 1;
          if (m_pread) m_wait = 1;
        end else begin
          e_tag = 16'h9800; e_s1 = '0; e_s2 = '0;
          e_s3 = {rx_slot3[19:4], 4'h0}; e_s4 = {rx_slot4[19:4], 4'h0};
          e_kind = m_after ? "R13" : "R6";
          m_after = 0;
        end
      end
      if (req_valid && !busy_old) begin
        m_pend = 1; m_pread = req_is_read; m_paddr = req_addr; m_pdata = req_wdata;
      end else if (req_valid && m_pend) m_ignored = 1;
      m_edges++;
      if (m_edges >= RST) m_crst = 1;
    end
    #5;
    if (!finished) begin
      chk("R1", "codec_rst_n", 32'(codec_rst_n), 32'(m_crst));
      chk(e_kind, "tx_tag", 32'(tx_tag), 32'(e_tag));
      chk(e_kind, "tx_slot1", 32'(tx_slot1), 32'(e_s1));
      chk(e_kind, "tx_slot2", 32'(tx_slot2), 32'(e_s2));
      chk(e_kind, "tx_slot3", 32'(tx_slot3), 32'(e_s3));
      chk(e_kind, "tx_slot4", 32'(tx_slot4), 32'(e_s4));
      chk("R7", "busy", 32'(busy), 32'(m_pend || m_wait));
      chk("R4", "init_done", 32'(init_done), 32'(m_done));
      chk(rd_kind, "rd_valid", 32'(rd_valid), 32'(e_rdv));
      if (e_rdv) begin
        chk("R10", "rd_addr", 32'(rd_addr), 32'(e_rda));
        chk("R10", "rd_data", 32'(rd_data), 32'(e_rdd));
      end
    end
  end

  // frame strobe generator, one pulse every GAP clocks
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    frame_strobe <= ((cyc % GAP) == 0);
  end

  task automatic frames(input int n);
    repeat (n) begin
      rx_slot3 = 20'($urandom);
      rx_slot4 = 20'($urandom);
      repeat (GAP) @(negedge clk);
    end
  endtask

  task automatic request(input bit rd, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_is_read = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic [6:0] a, input logic [15:0] d);
    rx_tag = 16'hE000;
    rx_slot1 = {1'b0, a, 12'hABC};
    rx_slot2 = {d, 4'h5};
    frames(1);
    rx_tag = 16'h8000; rx_slot1 = '0; rx_slot2 = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    frames(1);
    rx_tag = 16'h8000;            // R2: ready during codec reset is ignored
    frames(6);
    rx_tag = 16'h0000;            // R2: codec not ready
    frames(8);
    rx_tag = 16'h8000;            // R3, R4: init list
    frames(LEN + 3);              // R6: audio loop
    rx_tag = 16'h0000;            // R5: ready drop after init
    frames(2);
    rx_tag = 16'h8000;
    frames(2);
    request(1'b0, 7'h55, 16'hA5C3);   // R8 write
    request(1'b1, 7'h11, 16'h0000);   // R12 ignored while busy
    frames(3);                        // R13 audio follows
    respond(7'h33, 16'h7777);         // R11 no read outstanding
    request(1'b1, 7'h26, 16'h0);      // R9 read
    frames(2);
    respond(7'h26, 16'h1234);         // R10
    frames(2);
    request(1'b0, 7'h7F, 16'hFFFF);   // boundary write
    frames(2);
    request(1'b1, 7'h00, 16'h0);
    frames(2);
    respond(7'h00, 16'hFFFF);
    frames(2);
    rst_n = 1'b0;                     // second run: drop during init
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    frames(9);
    frames(2);
    rx_tag = 16'h0000;                // R5 mid-list
    frames(2);
    rx_tag = 16'h8000;
    frames(5);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule